// File: doc/BRIEF.md
# MESI Line State Controller

This block keeps the coherence state of every line of a small private first-level cache. Each line is in one of four states: Invalid (LN_INV), Shared (LN_SHR), Exclusive (LN_EXC) or Modified (LN_MOD). The line is chosen by the low address bits (the index). The rest of the address is kept per line as a tag, next to one data word. The local core issues reads and writes. The block answers with a registered response that says whether the access finished without any bus traffic (hit) or needed a bus transaction (miss). Other caches are represented by a shared lower level. That level sends snoops that ask this cache either to share a line or to give it up. When a dirty line must leave, the block returns its data.

The controller state machine has four states:

- **CTL_IDLE** accepts core requests.
- **CTL_EVICT** is a single cycle in which a dirty victim is written back.
- **CTL_FILL** waits for the grant of a read or of a read-for-ownership.
- **CTL_UPGRADE** waits for the grant of an ownership upgrade on a Shared line.

Its transitions are:

- IDLE to IDLE on a hit that completes at once.
- IDLE to UPGRADE on a write to a Shared line.
- IDLE to EVICT on a miss whose victim is Modified.
- IDLE to FILL on any other miss.
- EVICT to FILL unconditionally.
- FILL to IDLE on a grant.
- UPGRADE to IDLE on a grant.
- UPGRADE to FILL when a snoop invalidates the line while the upgrade is pending. The request then becomes a read-for-ownership.

Line state transitions:

| From | Event | To |
|---|---|---|
| LN_INV | read fill, grant not shared | LN_EXC |
| LN_INV | read fill, grant shared | LN_SHR |
| LN_INV | ownership fill | LN_MOD |
| LN_EXC | local write | LN_MOD |
| LN_SHR | upgrade grant | LN_MOD |
| any valid state | snoop-share | LN_SHR |
| any valid state | snoop-invalidate | LN_INV |
| any state | victim dropped on a miss | LN_INV |

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is LN_INV. `cpu_ready` is 1, and `bus_req_valid`, `cpu_resp_valid`, `wb_valid` and `snp_resp_valid` are 0. A snoop to any address answers miss.
- R2: A read miss raises `bus_req_valid` with kind 2'b00 (read). On the grant the line fills with `bus_gnt_data`. It fills in LN_SHR if `bus_gnt_shared` is 1, else in LN_EXC. One cycle after the grant, `cpu_resp_valid` is 1 with `cpu_resp_hit`=0 and the granted data.
- R3: A read to a valid line with a matching tag returns `cpu_resp_valid`=1, `cpu_resp_hit`=1 and the stored word one cycle after acceptance, with no bus request.
- R4: A write to an LN_EXC or LN_MOD line stores the word, leaves the line in LN_MOD, and responds with hit one cycle later, with no bus request.
- R5: A write to an LN_SHR line raises a bus request of kind 2'b10 (upgrade). Only after the grant does the word get stored, the line become LN_MOD, and a response with `cpu_resp_hit`=0 appear.
- R6: A write miss raises a bus request of kind 2'b01 (read-for-ownership). On the grant the line holds the written word in LN_MOD, and the response has `cpu_resp_hit`=0.
- R7: A snoop-share (`snp_inval`=0) that hits a line moves it to LN_SHR. From LN_MOD it answers `snp_resp_dirty`=1 with the stored word. From LN_EXC or LN_SHR it answers `snp_resp_dirty`=0.
- R8: A snoop-invalidate (`snp_inval`=1) that hits a line moves it to LN_INV. From LN_MOD it also answers `snp_resp_dirty`=1 with the stored word.
- R9: A snoop to a line that is LN_INV, or whose tag differs, answers `snp_resp_valid`=1 and `snp_resp_hit`=0, and changes no state.
- R10: When a snoop and a core request target the same index in the same cycle, the snoop is handled and `cpu_ready` is 0. The held request is accepted in a following cycle.
- R11: A miss whose victim line is LN_MOD first pulses `wb_valid` for one cycle with the victim's address and word. The bus request follows in the next cycle.
- R12: A snoop-invalidate that hits the line during a pending upgrade changes the request kind to 2'b01. The line is later filled in LN_MOD with the written word.
- R13: While `bus_req_valid` is 1 and no grant arrives, the request stays valid in the next cycle with the same address. The snoop priority of R10 and the conversion of R12 still apply.
- R14: Each snoop produces exactly one `snp_resp_valid` pulse, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Core request present; held until accepted |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Request address (low IDX_W bits are the index) |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | Request accepted at this edge when valid |
| cpu_resp_valid | output | 1 | Response pulse |
| cpu_resp_hit | output | 1 | 1 when the access needed no bus traffic |
| cpu_resp_rdata | output | DATA_W | Read word, or the written word for writes |
| bus_req_valid | output | 1 | Bus request pending until granted |
| bus_req_kind | output | 2 | 00 read, 01 read-for-ownership, 10 upgrade |
| bus_req_addr | output | ADDR_W | Address of the pending request |
| bus_gnt_valid | input | 1 | Grant for the pending request |
| bus_gnt_shared | input | 1 | Another cache holds the line (reads) |
| bus_gnt_data | input | DATA_W | Fill word for a read |
| wb_valid | output | 1 | Dirty victim writeback pulse |
| wb_addr | output | ADDR_W | Victim address |
| wb_data | output | DATA_W | Victim word |
| snp_valid | input | 1 | Snoop present |
| snp_inval | input | 1 | 1 = invalidate, 0 = share |
| snp_addr | input | ADDR_W | Snoop address |
| snp_resp_valid | output | 1 | Snoop response pulse |
| snp_resp_hit | output | 1 | Snoop found a valid line |
| snp_resp_dirty | output | 1 | Dirty word supplied |
| snp_resp_data | output | DATA_W | Supplied word (zero when not dirty) |

## Verification
A wrong line state cannot be seen directly at the ports. It shows up on the next access to that index, one cycle after that access is accepted:

- a wrong `cpu_resp_hit`;
- an unexpected bus request kind, such as an upgrade where a silent write was due;
- a missing `snp_resp_dirty`, which means lost dirty data.

The bench therefore follows each state-changing event with a probe that depends on the new state: a read, a write, or a snoop. A wrong request kind or a misplaced eviction shows one cycle after acceptance, on `bus_req_kind` or `wb_valid`.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'b00,
        LN_SHR = 2'b01,
        LN_EXC = 2'b10,
        LN_MOD = 2'b11
    } line_st_t;

    typedef enum logic [1:0] {
        BUS_RD  = 2'b00,
        BUS_RFO = 2'b01,
        BUS_UPG = 2'b10
    } bus_op_t;

    typedef enum logic [1:0] {
        CTL_IDLE,
        CTL_EVICT,
        CTL_FILL,
        CTL_UPGRADE
    } ctl_st_t;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    // local port
    input  logic [IDX_W-1:0]  loc_idx,
    input  logic              loc_we,
    input  line_st_t          loc_state,
    input  logic [TAG_W-1:0]  loc_tag,
    input  logic              loc_data_we,
    input  logic [DATA_W-1:0] loc_data,
    output line_st_t          loc_rd_state,
    output logic [TAG_W-1:0]  loc_rd_tag,
    output logic [DATA_W-1:0] loc_rd_data,
    // snoop port (state write wins over the local port)
    input  logic [IDX_W-1:0]  snp_idx,
    input  logic              snp_we,
    input  line_st_t          snp_state,
    output line_st_t          snp_rd_state,
    output logic [TAG_W-1:0]  snp_rd_tag,
    output logic [DATA_W-1:0] snp_rd_data
);

    line_st_t          st_vec  [LINES];
    logic [TAG_W-1:0]  tag_vec [LINES];
    logic [DATA_W-1:0] dat_vec [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        line_st_t          st_r;
        logic [TAG_W-1:0]  tag_r;
        logic [DATA_W-1:0] dat_r;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_r  <= LN_INV;
                tag_r <= '0;
                dat_r <= '0;
            end else begin
                if (snp_we && snp_idx == MY_IDX) begin
                    st_r <= snp_state;
                end else if (loc_we && loc_idx == MY_IDX) begin
                    st_r <= loc_state;
                end
                if (loc_we && loc_idx == MY_IDX) begin
                    tag_r <= loc_tag;
                end
                if (loc_data_we && loc_idx == MY_IDX) begin
                    dat_r <= loc_data;
                end
            end
        end

        assign st_vec[g]  = st_r;
        assign tag_vec[g] = tag_r;
        assign dat_vec[g] = dat_r;
    end

    assign loc_rd_state = st_vec[loc_idx];
    assign loc_rd_tag   = tag_vec[loc_idx];
    assign loc_rd_data  = dat_vec[loc_idx];
    assign snp_rd_state = st_vec[snp_idx];
    assign snp_rd_tag   = tag_vec[snp_idx];
    assign snp_rd_data  = dat_vec[snp_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic              snp_inval,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_t          line_state,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              upd_we,
    output line_st_t          upd_state,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_dirty,
    output logic [DATA_W-1:0] resp_data
);

    logic line_hit;
    logic line_dirty;

    assign line_hit   = snp_valid && (line_state != LN_INV) && (line_tag == snp_tag);
    assign line_dirty = line_hit && (line_state == LN_MOD);

    // next state of a snooped line; a write is issued only on a real change
    always_comb begin
        upd_state = line_state;
        if (line_hit) begin
            unique case (line_state)
                LN_MOD:  upd_state = snp_inval ? LN_INV : LN_SHR;
                LN_EXC:  upd_state = snp_inval ? LN_INV : LN_SHR;
                LN_SHR:  upd_state = snp_inval ? LN_INV : LN_SHR;
                LN_INV:  upd_state = LN_INV;
            endcase
        end
        upd_we = line_hit && (upd_state != line_state);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_dirty <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= snp_valid;
            resp_hit   <= line_hit;
            resp_dirty <= line_dirty;
            resp_data  <= line_dirty ? line_data : '0;
        end
    end

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    input  logic              snp_valid,
    input  logic [IDX_W-1:0]  snp_idx,
    input  logic              pend_killed,
    input  logic              bus_gnt_valid,
    input  logic              bus_gnt_shared,
    input  logic [DATA_W-1:0] bus_gnt_data,
    input  line_st_t          line_state,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic [IDX_W-1:0]  loc_idx,
    output logic              loc_we,
    output line_st_t          loc_state,
    output logic [TAG_W-1:0]  loc_tag,
    output logic              loc_data_we,
    output logic [DATA_W-1:0] loc_data,
    output logic              cpu_ready,
    output logic              cpu_resp_valid,
    output logic              cpu_resp_hit,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req_valid,
    output bus_op_t           bus_req_op,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);

    ctl_st_t           ctl_q, ctl_d;
    bus_op_t           op_q, op_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic              conflict, accept, tag_hit;
    logic              resp_fire, resp_hit_d, load_req, wb_fire, to_rfo;
    logic [DATA_W-1:0] resp_data_d;

    assign req_idx   = cpu_req_addr[IDX_W-1:0];
    assign req_tag   = cpu_req_addr[ADDR_W-1:IDX_W];
    assign conflict  = snp_valid && (snp_idx == req_idx);
    assign cpu_ready = (ctl_q == CTL_IDLE) && !conflict;
    assign accept    = cpu_req_valid && cpu_ready;
    assign tag_hit   = (line_state != LN_INV) && (line_tag == req_tag);
    assign loc_idx   = (ctl_q == CTL_IDLE) ? req_idx : addr_q[IDX_W-1:0];

    assign bus_req_valid = (ctl_q == CTL_FILL) || (ctl_q == CTL_UPGRADE);
    assign bus_req_op    = op_q;
    assign bus_req_addr  = addr_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // next state and line-update outputs
    always_comb begin
        ctl_d       = ctl_q;
        loc_we      = 1'b0;
        loc_state   = line_state;
        loc_tag     = line_tag;
        loc_data_we = 1'b0;
        loc_data    = line_data;
        resp_fire   = 1'b0;
        resp_hit_d  = 1'b0;
        resp_data_d = line_data;
        load_req    = 1'b0;
        op_d        = BUS_RD;
        wb_fire     = 1'b0;
        to_rfo      = 1'b0;
        unique case (ctl_q)
            CTL_IDLE: begin
                if (accept) begin
                    if (tag_hit && !cpu_req_write) begin
                        resp_fire  = 1'b1;
                        resp_hit_d = 1'b1;
                    end else if (tag_hit && (line_state == LN_EXC || line_state == LN_MOD)) begin
                        loc_we      = 1'b1;
                        loc_state   = LN_MOD;
                        loc_data_we = 1'b1;
                        loc_data    = cpu_req_wdata;
                        resp_fire   = 1'b1;
                        resp_hit_d  = 1'b1;
                        resp_data_d = cpu_req_wdata;
                    end else if (tag_hit) begin
                        load_req = 1'b1;
                        op_d     = BUS_UPG;
                        ctl_d    = CTL_UPGRADE;
                    end else begin
                        load_req  = 1'b1;
                        op_d      = cpu_req_write ? BUS_RFO : BUS_RD;
                        loc_we    = 1'b1;
                        loc_state = LN_INV;
                        if (line_state == LN_MOD) begin
                            wb_fire = 1'b1;
                            ctl_d   = CTL_EVICT;
                        end else begin
                            ctl_d   = CTL_FILL;
                        end
                    end
                end
            end
            CTL_EVICT: begin
                ctl_d = CTL_FILL;
            end
            CTL_FILL: begin
                if (bus_gnt_valid) begin
                    loc_we      = 1'b1;
                    loc_tag     = addr_q[ADDR_W-1:IDX_W];
                    loc_data_we = 1'b1;
                    if (op_q == BUS_RFO) begin
                        loc_state = LN_MOD;
                        loc_data  = wdata_q;
                    end else begin
                        loc_state = bus_gnt_shared ? LN_SHR : LN_EXC;
                        loc_data  = bus_gnt_data;
                    end
                    resp_fire   = 1'b1;
                    resp_data_d = (op_q == BUS_RFO) ? wdata_q : bus_gnt_data;
                    ctl_d       = CTL_IDLE;
                end
            end
            CTL_UPGRADE: begin
                if (pend_killed) begin
                    to_rfo = 1'b1;
                    ctl_d  = CTL_FILL;
                end else if (bus_gnt_valid) begin
                    loc_we      = 1'b1;
                    loc_state   = LN_MOD;
                    loc_data_we = 1'b1;
                    loc_data    = wdata_q;
                    resp_fire   = 1'b1;
                    resp_data_d = wdata_q;
                    ctl_d       = CTL_IDLE;
                end
            end
        endcase
    end

    // registered datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q           <= BUS_RD;
            addr_q         <= '0;
            wdata_q        <= '0;
            cpu_resp_valid <= 1'b0;
            cpu_resp_hit   <= 1'b0;
            cpu_resp_rdata <= '0;
            wb_valid       <= 1'b0;
            wb_addr        <= '0;
            wb_data        <= '0;
        end else begin
            cpu_resp_valid <= resp_fire;
            wb_valid       <= wb_fire;
            if (resp_fire) begin
                cpu_resp_hit   <= resp_hit_d;
                cpu_resp_rdata <= resp_data_d;
            end
            if (load_req) begin
                op_q    <= op_d;
                addr_q  <= cpu_req_addr;
                wdata_q <= cpu_req_wdata;
            end else if (to_rfo) begin
                op_q    <= BUS_RFO;
            end
            if (wb_fire) begin
                wb_addr <= {line_tag, req_idx};
                wb_data <= line_data;
            end
        end
    end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LINES  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_ready,
    output logic              cpu_resp_valid,
    output logic              cpu_resp_hit,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_kind,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_gnt_valid,
    input  logic              bus_gnt_shared,
    input  logic [DATA_W-1:0] bus_gnt_data,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    input  logic              snp_valid,
    input  logic              snp_inval,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_resp_valid,
    output logic              snp_resp_hit,
    output logic              snp_resp_dirty,
    output logic [DATA_W-1:0] snp_resp_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  loc_idx;
    logic              loc_we, loc_data_we;
    line_st_t          loc_state, loc_rd_state;
    logic [TAG_W-1:0]  loc_tag, loc_rd_tag;
    logic [DATA_W-1:0] loc_data, loc_rd_data;

    logic [IDX_W-1:0]  snp_idx;
    logic [TAG_W-1:0]  snp_tag;
    logic              snp_we;
    line_st_t          snp_state, snp_rd_state;
    logic [TAG_W-1:0]  snp_rd_tag;
    logic [DATA_W-1:0] snp_rd_data;

    logic              pend_killed;
    bus_op_t           bus_req_op;

    assign snp_idx      = snp_addr[IDX_W-1:0];
    assign snp_tag      = snp_addr[ADDR_W-1:IDX_W];
    assign pend_killed  = snp_we && (snp_state == LN_INV) && (snp_idx == loc_idx);
    assign bus_req_kind = bus_req_op;

    mesi_line_store #(
        .LINES (LINES),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .loc_idx     (loc_idx),
        .loc_we      (loc_we),
        .loc_state   (loc_state),
        .loc_tag     (loc_tag),
        .loc_data_we (loc_data_we),
        .loc_data    (loc_data),
        .loc_rd_state(loc_rd_state),
        .loc_rd_tag  (loc_rd_tag),
        .loc_rd_data (loc_rd_data),
        .snp_idx     (snp_idx),
        .snp_we      (snp_we),
        .snp_state   (snp_state),
        .snp_rd_state(snp_rd_state),
        .snp_rd_tag  (snp_rd_tag),
        .snp_rd_data (snp_rd_data)
    );

    mesi_snoop_unit #(
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) snoop_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .snp_valid (snp_valid),
        .snp_inval (snp_inval),
        .snp_tag   (snp_tag),
        .line_state(snp_rd_state),
        .line_tag  (snp_rd_tag),
        .line_data (snp_rd_data),
        .upd_we    (snp_we),
        .upd_state (snp_state),
        .resp_valid(snp_resp_valid),
        .resp_hit  (snp_resp_hit),
        .resp_dirty(snp_resp_dirty),
        .resp_data (snp_resp_data)
    );

    mesi_req_fsm #(
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W),
        .DATA_W(DATA_W)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_write (cpu_req_write),
        .cpu_req_addr  (cpu_req_addr),
        .cpu_req_wdata (cpu_req_wdata),
        .snp_valid     (snp_valid),
        .snp_idx       (snp_idx),
        .pend_killed   (pend_killed),
        .bus_gnt_valid (bus_gnt_valid),
        .bus_gnt_shared(bus_gnt_shared),
        .bus_gnt_data  (bus_gnt_data),
        .line_state    (loc_rd_state),
        .line_tag      (loc_rd_tag),
        .line_data     (loc_rd_data),
        .loc_idx       (loc_idx),
        .loc_we        (loc_we),
        .loc_state     (loc_state),
        .loc_tag       (loc_tag),
        .loc_data_we   (loc_data_we),
        .loc_data      (loc_data),
        .cpu_ready     (cpu_ready),
        .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_hit  (cpu_resp_hit),
        .cpu_resp_rdata(cpu_resp_rdata),
        .bus_req_valid (bus_req_valid),
        .bus_req_op    (bus_req_op),
        .bus_req_addr  (bus_req_addr),
        .wb_valid      (wb_valid),
        .wb_addr       (wb_addr),
        .wb_data       (wb_data)
    );

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic [IDX_W-1:0]  cpu_idx,
    input logic              cpu_ready,
    input logic              cpu_resp_valid,
    input logic              cpu_resp_hit,
    input logic              bus_req_valid,
    input logic [1:0]        bus_req_kind,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic              bus_gnt_valid,
    input logic              wb_valid,
    input logic              snp_valid,
    input logic [IDX_W-1:0]  snp_idx,
    input logic              snp_resp_valid,
    input logic              snp_resp_hit,
    input logic              snp_resp_dirty
);

    // R10
    snoop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && cpu_req_valid && snp_idx == cpu_idx) |-> !cpu_ready);

    // R13
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_gnt_valid) |=> (bus_req_valid && $stable(bus_req_addr)));

    // R11
    evict_then_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> bus_req_valid);

    // R7
    dirty_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_resp_dirty |-> (snp_resp_hit && snp_resp_valid));

    // R14
    snoop_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> snp_resp_valid);

    // R2
    read_fill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_gnt_valid && bus_req_kind == 2'b00) |=> (cpu_resp_valid && !cpu_resp_hit));

    // R3
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_resp_valid, bus_req_valid, wb_valid}));

    // R5
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> !cpu_ready);

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_idx       (cpu_req_addr[IDX_W-1:0]),
    .cpu_ready     (cpu_ready),
    .cpu_resp_valid(cpu_resp_valid),
    .cpu_resp_hit  (cpu_resp_hit),
    .bus_req_valid (bus_req_valid),
    .bus_req_kind  (bus_req_kind),
    .bus_req_addr  (bus_req_addr),
    .bus_gnt_valid (bus_gnt_valid),
    .wb_valid      (wb_valid),
    .snp_valid     (snp_valid),
    .snp_idx       (snp_addr[IDX_W-1:0]),
    .snp_resp_valid(snp_resp_valid),
    .snp_resp_hit  (snp_resp_hit),
    .snp_resp_dirty(snp_resp_dirty)
);

// File: tb/mesi_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb_top;

    localparam int ADDR_W = 8;
    localparam int LINES  = 4;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req_valid = 1'b0;
    logic              cpu_req_write = 1'b0;
    logic [ADDR_W-1:0] cpu_req_addr = '0;
    logic [DATA_W-1:0] cpu_req_wdata = '0;
    logic              cpu_ready, cpu_resp_valid, cpu_resp_hit;
    logic [DATA_W-1:0] cpu_resp_rdata;
    logic              bus_req_valid;
    logic [1:0]        bus_req_kind;
    logic [ADDR_W-1:0] bus_req_addr;
    logic              bus_gnt_valid = 1'b0;
    logic              bus_gnt_shared = 1'b0;
    logic [DATA_W-1:0] bus_gnt_data = '0;
    logic              wb_valid;
    logic [ADDR_W-1:0] wb_addr;
    logic [DATA_W-1:0] wb_data;
    logic              snp_valid = 1'b0;
    logic              snp_inval = 1'b0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              snp_resp_valid, snp_resp_hit, snp_resp_dirty;
    logic [DATA_W-1:0] snp_resp_data;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mesi_line_ctrl #(.ADDR_W(ADDR_W), .LINES(LINES), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_ready(cpu_ready), .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_hit(cpu_resp_hit), .cpu_resp_rdata(cpu_resp_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_kind(bus_req_kind),
        .bus_req_addr(bus_req_addr), .bus_gnt_valid(bus_gnt_valid),
        .bus_gnt_shared(bus_gnt_shared), .bus_gnt_data(bus_gnt_data),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
        .snp_valid(snp_valid), .snp_inval(snp_inval), .snp_addr(snp_addr),
        .snp_resp_valid(snp_resp_valid), .snp_resp_hit(snp_resp_hit),
        .snp_resp_dirty(snp_resp_dirty), .snp_resp_data(snp_resp_data)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one core access; exp_kind/gnt fields used only on a miss
    task automatic cpu_access(input string req, input bit wr, input logic [ADDR_W-1:0] addr,
                              input logic [DATA_W-1:0] wd, input bit exp_hit, input logic [1:0] exp_kind,
                              input bit gshared, input logic [DATA_W-1:0] gdata,
                              input logic [DATA_W-1:0] exp_rdata, input bit exp_wb,
                              input logic [ADDR_W-1:0] exp_wb_addr, input logic [DATA_W-1:0] exp_wb_data);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = addr; cpu_req_wdata = wd;
        for (int i = 0; i < 20 && !cpu_ready; i++) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        if (exp_hit) begin
            chk(req, "hit resp_valid", cpu_resp_valid, 1);
            chk(req, "hit flag", cpu_resp_hit, 1);
            chk(req, "hit rdata", cpu_resp_rdata, exp_rdata);
            chk(req, "hit no bus", bus_req_valid, 0);
        end else begin
            chk(req, "wb pulse", wb_valid, exp_wb);
            if (exp_wb) begin
                chk("R11", "wb addr", wb_addr, exp_wb_addr);
                chk("R11", "wb data", wb_data, exp_wb_data);
                @(negedge clk);
            end
            chk(req, "bus valid", bus_req_valid, 1);
            chk(req, "bus kind", bus_req_kind, exp_kind);
            chk(req, "bus addr", bus_req_addr, addr);
            @(negedge clk);
            chk("R13", "bus held", bus_req_valid, 1);
            chk("R13", "bus addr held", bus_req_addr, addr);
            bus_gnt_valid = 1'b1; bus_gnt_shared = gshared; bus_gnt_data = gdata;
            @(negedge clk);
            bus_gnt_valid = 1'b0; bus_gnt_shared = 1'b0;
            chk(req, "miss resp_valid", cpu_resp_valid, 1);
            chk(req, "miss flag", cpu_resp_hit, 0);
            chk(req, "miss rdata", cpu_resp_rdata, exp_rdata);
        end
    endtask

    task automatic snoop(input string req, input bit inv, input logic [ADDR_W-1:0] addr,
                         input bit exp_hit, input bit exp_dirty, input logic [DATA_W-1:0] exp_data);
        @(negedge clk);
        snp_valid = 1'b1; snp_inval = inv; snp_addr = addr;
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
        chk(req, "snoop resp_valid", snp_resp_valid, 1);
        chk(req, "snoop hit", snp_resp_hit, exp_hit);
        chk(req, "snoop dirty", snp_resp_dirty, exp_dirty);
        chk(req, "snoop data", snp_resp_data, exp_data);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "ready", cpu_ready, 1);
        chk("R1", "bus idle", bus_req_valid, 0);
        chk("R1", "no resp", cpu_resp_valid, 0);
        chk("R1", "no wb", wb_valid, 0);
        chk("R1", "no snoop resp", snp_resp_valid, 0);
        snoop("R1", 1'b0, 8'h10, 0, 0, 16'h0);
    endtask

    task automatic t_exclusive_path();
        cpu_access("R2", 0, 8'h10, 16'h0, 0, 2'b00, 0, 16'h1111, 16'h1111, 0, 0, 0);
        cpu_access("R3", 0, 8'h10, 16'h0, 1, 2'b00, 0, 0, 16'h1111, 0, 0, 0);
        cpu_access("R4", 1, 8'h10, 16'hAAAA, 1, 2'b00, 0, 0, 16'hAAAA, 0, 0, 0);
        cpu_access("R4", 1, 8'h10, 16'hBBBB, 1, 2'b00, 0, 0, 16'hBBBB, 0, 0, 0);
        snoop("R7", 1'b0, 8'h10, 1, 1, 16'hBBBB);
        cpu_access("R5", 1, 8'h10, 16'hCCCC, 0, 2'b10, 0, 16'h0, 16'hCCCC, 0, 0, 0);
        cpu_access("R5", 0, 8'h10, 16'h0, 1, 2'b00, 0, 0, 16'hCCCC, 0, 0, 0);
        snoop("R8", 1'b1, 8'h10, 1, 1, 16'hCCCC);
        cpu_access("R8", 0, 8'h10, 16'h0, 0, 2'b00, 1, 16'h2222, 16'h2222, 0, 0, 0);
        snoop("R7", 1'b0, 8'h10, 1, 0, 16'h0);
        snoop("R8", 1'b1, 8'h10, 1, 0, 16'h0);
        snoop("R9", 1'b0, 8'h10, 0, 0, 16'h0);
    endtask

    task automatic t_share_downgrade();
        cpu_access("R2", 0, 8'h21, 16'h0, 0, 2'b00, 0, 16'h3333, 16'h3333, 0, 0, 0);
        snoop("R7", 1'b0, 8'h21, 1, 0, 16'h0);
        cpu_access("R7", 1, 8'h21, 16'h4444, 0, 2'b10, 0, 16'h0, 16'h4444, 0, 0, 0);
        snoop("R9", 1'b1, 8'h25, 0, 0, 16'h0);
        cpu_access("R9", 0, 8'h21, 16'h0, 1, 2'b00, 0, 0, 16'h4444, 0, 0, 0);
    endtask

    task automatic t_evict_and_rfo();
        cpu_access("R11", 1, 8'h05, 16'h5555, 0, 2'b01, 0, 16'hDEAD, 16'h5555, 1, 8'h21, 16'h4444);
        cpu_access("R6", 0, 8'h05, 16'h0, 1, 2'b00, 0, 0, 16'h5555, 0, 0, 0);
        cpu_access("R6", 1, 8'h02, 16'h6666, 0, 2'b01, 0, 16'hBEEF, 16'h6666, 0, 0, 0);
        cpu_access("R6", 0, 8'h02, 16'h0, 1, 2'b00, 0, 0, 16'h6666, 0, 0, 0);
    endtask

    task automatic t_conflict();
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = 8'h02;
        snp_valid = 1'b1; snp_inval = 1'b0; snp_addr = 8'h02;
        #1;
        chk("R10", "ready low on clash", cpu_ready, 0);
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
        chk("R10", "snoop served dirty", snp_resp_dirty, 1);
        chk("R10", "snoop data", snp_resp_data, 16'h6666);
        chk("R10", "no early resp", cpu_resp_valid, 0);
        #1;
        chk("R10", "ready after clash", cpu_ready, 1);
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        chk("R10", "retry resp", cpu_resp_valid, 1);
        chk("R10", "retry hit on S", cpu_resp_hit, 1);
        chk("R10", "retry rdata", cpu_resp_rdata, 16'h6666);
        cpu_access("R7", 1, 8'h02, 16'h6767, 0, 2'b10, 0, 16'h0, 16'h6767, 0, 0, 0);
    endtask

    task automatic t_upgrade_lost();
        cpu_access("R2", 0, 8'h13, 16'h0, 0, 2'b00, 1, 16'h7777, 16'h7777, 0, 0, 0);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = 8'h13; cpu_req_wdata = 16'h8888;
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        chk("R12", "upgrade pending", bus_req_valid, 1);
        chk("R12", "upgrade kind", bus_req_kind, 2'b10);
        snp_valid = 1'b1; snp_inval = 1'b1; snp_addr = 8'h13;
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
        chk("R12", "snoop hit", snp_resp_hit, 1);
        chk("R12", "snoop clean", snp_resp_dirty, 0);
        chk("R12", "still pending", bus_req_valid, 1);
        chk("R12", "kind now rfo", bus_req_kind, 2'b01);
        bus_gnt_valid = 1'b1; bus_gnt_data = 16'h9999;
        @(negedge clk);
        bus_gnt_valid = 1'b0;
        chk("R12", "resp", cpu_resp_valid, 1);
        chk("R12", "resp miss", cpu_resp_hit, 0);
        cpu_access("R12", 0, 8'h13, 16'h0, 1, 2'b00, 0, 0, 16'h8888, 0, 0, 0);
        cpu_access("R12", 1, 8'h13, 16'h8989, 1, 2'b00, 0, 0, 16'h8989, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_exclusive_path();
        t_share_downgrade();
        t_evict_and_rfo();
        t_conflict();
        t_upgrade_lost();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule